// File: doc/BRIEF.md
# Long-Format Instruction Decoder

This block sits at the front of an instruction pipeline. It takes instruction bytes one per cycle, lowest byte first, and works out how long each instruction is. After two bytes it shows the 16-bit word to an external short-format decoder. If that decoder accepts the word, the result is a 2-byte instruction. If it rejects the word, the block collects two more bytes and decodes the 32-bit word itself under the long-format rules.

The long-format rules work on the low halfword's major field. Each halfword reuses the short forms' packing for two or three operands. A 9-bit extended opcode is made from two separate bit fields and picks one of the three-register, immediate, bit-position and CRC forms. Other major values select a five-register form that falls back to a six-register multiply, or one of two four-register forms where a source is also a destination.

Each result is held on the output until it is accepted. A result carries the length, a fail flag, an opcode code and an ordered list of up to six 4-bit operand slots. Each slot has an immediate flag, and a bit-position value is given where the form has one.

Top module: `long_insn_decoder`

## Requirements
- R1: Bytes are little-endian. `shortWord` is {byte1, byte0} while `shortQuery` is high. The long word is {byte3, byte2, byte1, byte0}.
- R2: The short decoder is asked first. If `shortOk` is high during the query, the result has length 2, opcode SHORT (1), no fail and no operands. Only two bytes are taken.
- R3: If the stream ends (`inLast` on an accepted byte) before a decodable word is complete, the result has length 0 and fail set. This covers a 1-byte stream, a 2-byte stream the short decoder rejects, and a 3-byte stream.
- R4: Major field `lo[15:11]`=0x1F with a low halfword that is not a valid two-operand word selects the extended opcode {word[31:27], word[19:16]}. Values 0x0c..0x9c in steps of 0x10 give the three-register ops STW, XOR, ASHR, LAWF, LAWB, LAHF, LAHB, MUL, DIVS, DIVU. 0x10c and 0x11c give STH and STB, and 0x18c and 0x19c give REMS and REMU. Operands are op1, op2, op3 from the three-operand packing. A low halfword whose combined field `lo[10:6]` is 27 or more fails.
- R5: Extended 0x12c, 0x12d and 0x12e (ASHRI, OUTP, INP) and 0x13c and 0x14c (LAWFI, LAWBI) put op3 as an immediate in slot 2 with `outImm[2]` set. The bit-position forms also give `outBitPos` from the map 0→32, 1..8→same, 9→16, 10→24, 11→32.
- R6: Extended 0x15c (CRC) gives op1, op1, op2, op3 with a count of 4.
- R7: Any other extended value fails with length 4. A failed result has opcode NONE (0), count 0, all slots 0 and no immediate flags.
- R8: Major 0x1F with a valid two-operand low halfword (combined 27..31, and not 31 with `lo[5]` set) gives WIDE2R with op1, op2.
- R9: Major 0x1E decodes the low halfword as three operands and the high halfword as two. It gives REG5 with op1, op4, op2, op3, op5.
- R10: If either half of the major 0x1E form fails and word[31:27] is 0, both halves are decoded as three operands. This gives LMUL6 with op1, op4, op2, op3, op5, op6. Otherwise the word fails.
- R11: Major 0x1D (SD4: op1, op4, op4, op2, op3) and 0x1C (SDSD4: op1, op4, op1, op4, op2, op3) take op4 from word[19:16], and it must not exceed 11. Every register slot of a good result is in 0..11.
- R12: `inReady` is low while a result waits. The result stays unchanged until `outReady` takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inByte | input | 8 | Instruction byte |
| inValid | input | 1 | Byte offered |
| inLast | input | 1 | Offered byte ends the stream |
| inReady | output | 1 | Byte can be accepted |
| shortWord | output | 16 | 16-bit word shown to the short decoder |
| shortQuery | output | 1 | Short decoder result is sampled this cycle |
| shortOk | input | 1 | Short decoder accepts `shortWord` |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Result taken |
| outLen | output | 3 | Length in bytes: 0, 2 or 4 |
| outFail | output | 1 | Decode failed |
| outOpcode | output | 5 | Opcode code |
| outSlots | output | 24 | Six 4-bit operand slots, slot 0 in bits 3:0 |
| outCount | output | 3 | Number of filled slots |
| outImm | output | 6 | Per-slot immediate flag |
| outBitPos | output | 6 | Mapped bit-position value |

## Verification
Words are built from chosen register numbers, so each slot value identifies the field it came from. A wrong operand order or a wrong packing split therefore shows up as a specific slot mismatch. The extended path is tried with table entries, immediate and bit-position entries, the CRC entry, an unknown value and a low halfword whose combined field separates the two-operand and three-operand cases. The five-register words check fallback to six registers, and that a nonzero word[31:27] stops the fallback. The four-register words are tried with op4 at 7, 11 and 12 to find the range limit. Short-accepted words and streams cut after one, two and three bytes separate the 2-byte, 4-byte and 0-length outcomes.

// File: rtl/lid_pkg.sv
package lid_pkg;
  localparam int unsigned SLOT_W    = 4;
  localparam int unsigned NUM_SLOTS = 6;
  localparam int unsigned SLOTS_W   = SLOT_W * NUM_SLOTS;
  localparam int unsigned OPC_W     = 5;
  localparam int unsigned CNT_W     = 3;
  localparam int unsigned BP_W      = 6;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned HALF_W    = 2 * BYTE_W;
  localparam int unsigned WORD_W    = 4 * BYTE_W;

  typedef enum logic [OPC_W-1:0] {
    OPC_NONE, OPC_SHORT, OPC_WIDE2R,
    OPC_STW, OPC_XOR, OPC_ASHR, OPC_LAWF, OPC_LAWB, OPC_LAHF, OPC_LAHB,
    OPC_MUL, OPC_DIVS, OPC_DIVU, OPC_STH, OPC_STB,
    OPC_ASHRI, OPC_OUTP, OPC_INP, OPC_LAWFI, OPC_LAWBI,
    OPC_CRC, OPC_REMS, OPC_REMU, OPC_REG5, OPC_LMUL6, OPC_SD4, OPC_SDSD4
  } opc_e;

  typedef enum logic [1:0] {K_R3, K_IMM, K_BIT, K_CRC} kind_e;

  typedef struct packed {
    logic             ok;
    logic [SLOT_W-1:0] a;
    logic [SLOT_W-1:0] b;
    logic [SLOT_W-1:0] c;
  } ops_t;

  typedef struct packed {
    logic       ldEn;
    logic [1:0] ldIdx;
    logic       capShort;
    logic       capLong;
    logic       capTrunc;
  } strobe_t;

  typedef struct packed {
    logic               fail;
    opc_e               opc;
    logic [SLOTS_W-1:0] slots;
    logic [CNT_W-1:0]   cnt;
    logic [NUM_SLOTS-1:0] imm;
    logic [BP_W-1:0]    bitPos;
  } res_t;

  // Three operands packed in one halfword: base-3 high digits in [10:6].
  function automatic ops_t split3(input logic [HALF_W-1:0] h);
    ops_t r;
    logic [4:0] k;
    k = h[10:6];
    r = '0;
    r.ok = (k < 5'd27);
    if (r.ok) begin
      r.a = {2'(k % 5'd3), h[5:4]};
      r.b = {2'((k / 5'd3) % 5'd3), h[3:2]};
      r.c = {2'(k / 5'd9), h[1:0]};
    end
    return r;
  endfunction

  // Two operands packed in one halfword: combined 27..31, bit 5 adds 5.
  function automatic ops_t split2(input logic [HALF_W-1:0] h);
    ops_t r;
    logic [5:0] k;
    k = {1'b0, h[10:6]};
    r = '0;
    r.ok = (k >= 6'd27) && !(h[5] && (k == 6'd31));
    if (r.ok) begin
      if (h[5]) k = k + 6'd5;
      k = k - 6'd27;
      r.a = {2'(k % 6'd3), h[3:2]};
      r.b = {2'(k / 6'd3), h[1:0]};
    end
    return r;
  endfunction

  function automatic logic [BP_W-1:0] bitPosOf(input logic [SLOT_W-1:0] code);
    logic [BP_W-1:0] v;
    case (code)
      4'd0, 4'd11: v = 6'd32;
      4'd9:        v = 6'd16;
      4'd10:       v = 6'd24;
      4'd12, 4'd13, 4'd14, 4'd15: v = 6'd0;
      default:     v = {2'b00, code};
    endcase
    return v;
  endfunction
endpackage

// File: rtl/lid_ctrl.sv
module lid_ctrl
  import lid_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inLast,
  input  logic    shortOk,
  input  logic    outReady,
  output logic    inReady,
  output logic    shortQuery,
  output logic    outValid,
  output strobe_t strb
);
  typedef enum logic [2:0] {S_B0, S_B1, S_Q16, S_B2, S_B3, S_WD, S_OUT} st_e;

  st_e  state, stateNext;
  logic lastQ, lastNext;
  logic accept;

  assign inReady    = (state == S_B0) || (state == S_B1) || (state == S_B2) || (state == S_B3);
  assign shortQuery = (state == S_Q16);
  assign outValid   = (state == S_OUT);
  assign accept     = inValid && inReady;

  always_comb begin
    stateNext = state;
    lastNext  = lastQ;
    strb      = '0;
    case (state)
      S_B0: if (accept) begin
        strb.ldEn = 1'b1; strb.ldIdx = 2'd0;
        if (inLast) begin strb.capTrunc = 1'b1; stateNext = S_OUT; end
        else stateNext = S_B1;
      end
      S_B1: if (accept) begin
        strb.ldEn = 1'b1; strb.ldIdx = 2'd1;
        lastNext  = inLast;
        stateNext = S_Q16;
      end
      S_Q16: begin
        if (shortOk) begin strb.capShort = 1'b1; stateNext = S_OUT; end
        else if (lastQ) begin strb.capTrunc = 1'b1; stateNext = S_OUT; end
        else stateNext = S_B2;
      end
      S_B2: if (accept) begin
        strb.ldEn = 1'b1; strb.ldIdx = 2'd2;
        if (inLast) begin strb.capTrunc = 1'b1; stateNext = S_OUT; end
        else stateNext = S_B3;
      end
      S_B3: if (accept) begin
        strb.ldEn = 1'b1; strb.ldIdx = 2'd3;
        stateNext = S_WD;
      end
      S_WD: begin
        strb.capLong = 1'b1;
        stateNext = S_OUT;
      end
      S_OUT: if (outReady) stateNext = S_B0;
      default: stateNext = S_B0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_B0;
      lastQ <= 1'b0;
    end else begin
      state <= stateNext;
      lastQ <= lastNext;
    end
  end
endmodule

// File: rtl/lid_dpath.sv
module lid_dpath
  import lid_pkg::*;
#(
  parameter int unsigned REG_LIMIT = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [BYTE_W-1:0]   inByte,
  input  strobe_t             strb,
  output logic [HALF_W-1:0]   shortWord,
  output res_t                resQ,
  output logic [2:0]          lenQ
);
  logic [BYTE_W-1:0] byteQ [4];
  logic [WORD_W-1:0] wordQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) byteQ[i] <= '0;
    end else if (strb.ldEn) begin
      byteQ[strb.ldIdx] <= inByte;
    end
  end

  assign shortWord = {byteQ[1], byteQ[0]};
  assign wordQ     = {byteQ[3], byteQ[2], byteQ[1], byteQ[0]};

  // Long-format decode cone
  logic [HALF_W-1:0] lo, hi;
  logic [4:0]        major;
  logic [8:0]        ext;
  logic [3:0]        r4;
  ops_t              l3, l2, h3, h2;
  logic [SLOT_W-1:0] s [NUM_SLOTS];
  logic [CNT_W-1:0]  n;
  logic [NUM_SLOTS-1:0] im;
  logic [BP_W-1:0]   bp;
  opc_e              opc;
  kind_e             kind;
  logic              ok, extHit;
  logic [SLOTS_W-1:0] slotsFlat;
  res_t              longRes;

  always_comb begin
    lo    = wordQ[HALF_W-1:0];
    hi    = wordQ[WORD_W-1:HALF_W];
    major = lo[15:11];
    ext   = {wordQ[31:27], wordQ[19:16]};
    r4    = wordQ[19:16];
    l3 = split3(lo);
    l2 = split2(lo);
    h3 = split3(hi);
    h2 = split2(hi);
    for (int i = 0; i < NUM_SLOTS; i++) s[i] = '0;
    n = '0; im = '0; bp = '0; opc = OPC_NONE; kind = K_R3; ok = 1'b0; extHit = 1'b1;
    case (major)
      5'h1F: begin
        if (l2.ok) begin
          ok = 1'b1; opc = OPC_WIDE2R; s[0] = l2.a; s[1] = l2.b; n = 3'd2;
        end else begin
          case (ext)
            9'h00c: opc = OPC_STW;
            9'h01c: opc = OPC_XOR;
            9'h02c: opc = OPC_ASHR;
            9'h03c: opc = OPC_LAWF;
            9'h04c: opc = OPC_LAWB;
            9'h05c: opc = OPC_LAHF;
            9'h06c: opc = OPC_LAHB;
            9'h07c: opc = OPC_MUL;
            9'h08c: opc = OPC_DIVS;
            9'h09c: opc = OPC_DIVU;
            9'h10c: opc = OPC_STH;
            9'h11c: opc = OPC_STB;
            9'h12c: begin opc = OPC_ASHRI; kind = K_BIT; end
            9'h12d: begin opc = OPC_OUTP;  kind = K_BIT; end
            9'h12e: begin opc = OPC_INP;   kind = K_BIT; end
            9'h13c: begin opc = OPC_LAWFI; kind = K_IMM; end
            9'h14c: begin opc = OPC_LAWBI; kind = K_IMM; end
            9'h15c: begin opc = OPC_CRC;   kind = K_CRC; end
            9'h18c: opc = OPC_REMS;
            9'h19c: opc = OPC_REMU;
            default: extHit = 1'b0;
          endcase
          if (extHit && l3.ok) begin
            ok = 1'b1;
            if (kind == K_CRC) begin
              s[0] = l3.a; s[1] = l3.a; s[2] = l3.b; s[3] = l3.c; n = 3'd4;
            end else begin
              s[0] = l3.a; s[1] = l3.b; s[2] = l3.c; n = 3'd3;
              if (kind != K_R3) im[2] = 1'b1;
              if (kind == K_BIT) bp = bitPosOf(l3.c);
            end
          end
        end
      end
      5'h1E: begin
        if (l3.ok && h2.ok) begin
          ok = 1'b1; opc = OPC_REG5; n = 3'd5;
          s[0] = l3.a; s[1] = h2.a; s[2] = l3.b; s[3] = l3.c; s[4] = h2.b;
        end else if ((wordQ[31:27] == 5'd0) && l3.ok && h3.ok) begin
          ok = 1'b1; opc = OPC_LMUL6; n = 3'd6;
          s[0] = l3.a; s[1] = h3.a; s[2] = l3.b; s[3] = l3.c; s[4] = h3.b; s[5] = h3.c;
        end
      end
      5'h1D, 5'h1C: begin
        if (l3.ok && (32'(r4) <= REG_LIMIT)) begin
          ok = 1'b1;
          if (major == 5'h1D) begin
            opc = OPC_SD4; n = 3'd5;
            s[0] = l3.a; s[1] = r4; s[2] = r4; s[3] = l3.b; s[4] = l3.c;
          end else begin
            opc = OPC_SDSD4; n = 3'd6;
            s[0] = l3.a; s[1] = r4; s[2] = l3.a; s[3] = r4; s[4] = l3.b; s[5] = l3.c;
          end
        end
      end
      default: ok = 1'b0;
    endcase
    if (!ok) begin
      for (int i = 0; i < NUM_SLOTS; i++) s[i] = '0;
      n = '0; im = '0; bp = '0; opc = OPC_NONE;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : gPack
      assign slotsFlat[g*SLOT_W +: SLOT_W] = s[g];
    end
  endgenerate

  always_comb begin
    longRes.fail   = !ok;
    longRes.opc    = opc;
    longRes.slots  = slotsFlat;
    longRes.cnt    = n;
    longRes.imm    = im;
    longRes.bitPos = bp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resQ <= '0;
      lenQ <= '0;
    end else if (strb.capLong) begin
      resQ <= longRes;
      lenQ <= 3'd4;
    end else if (strb.capShort) begin
      resQ     <= '0;
      resQ.opc <= OPC_SHORT;
      lenQ     <= 3'd2;
    end else if (strb.capTrunc) begin
      resQ      <= '0;
      resQ.fail <= 1'b1;
      lenQ      <= 3'd0;
    end
  end
endmodule

// File: rtl/long_insn_decoder.sv
module long_insn_decoder
  import lid_pkg::*;
#(
  parameter int unsigned REG_LIMIT = 11
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   inByte,
  input  logic         inValid,
  input  logic         inLast,
  output logic         inReady,
  output logic [15:0]  shortWord,
  output logic         shortQuery,
  input  logic         shortOk,
  output logic         outValid,
  input  logic         outReady,
  output logic [2:0]   outLen,
  output logic         outFail,
  output logic [4:0]   outOpcode,
  output logic [23:0]  outSlots,
  output logic [2:0]   outCount,
  output logic [5:0]   outImm,
  output logic [5:0]   outBitPos
);
  strobe_t strb;
  res_t    resQ;

  lid_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .shortOk(shortOk), .outReady(outReady), .inReady(inReady),
    .shortQuery(shortQuery), .outValid(outValid), .strb(strb)
  );

  lid_dpath #(.REG_LIMIT(REG_LIMIT)) uDpath (
    .clk(clk), .rstN(rstN), .inByte(inByte), .strb(strb),
    .shortWord(shortWord), .resQ(resQ), .lenQ(outLen)
  );

  assign outFail   = resQ.fail;
  assign outOpcode = resQ.opc;
  assign outSlots  = resQ.slots;
  assign outCount  = resQ.cnt;
  assign outImm    = resQ.imm;
  assign outBitPos = resQ.bitPos;
endmodule

// File: rtl/lid_checker.sv
module lid_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [2:0]  outLen,
  input logic        outFail,
  input logic [4:0]  outOpcode,
  input logic [23:0] outSlots,
  input logic [2:0]  outCount,
  input logic [5:0]  outImm
);
  logic slotsInRange;
  always_comb begin
    slotsInRange = 1'b1;
    for (int i = 0; i < 6; i++)
      if (outSlots[i*4 +: 4] > 4'd11) slotsInRange = 1'b0;
  end

  assert_result_held_R12: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outSlots) && $stable(outOpcode) && $stable(outLen));

  assert_no_accept_while_held_R12: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  assert_zero_len_fails_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid && (outLen == 3'd0) |-> outFail);

  assert_fail_is_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outFail |-> (outCount == 3'd0) && (outImm == 6'd0) && (outSlots == 24'd0));

  assert_short_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid && (outOpcode == 5'd1) |-> (outLen == 3'd2) && !outFail);

  assert_reg_range_R11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outFail |-> slotsInRange);
endmodule

bind long_insn_decoder lid_checker uChecker (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid),
  .outReady(outReady), .outLen(outLen), .outFail(outFail),
  .outOpcode(outOpcode), .outSlots(outSlots), .outCount(outCount), .outImm(outImm)
);

// File: tb/tb_long_insn_decoder.sv
module tb_long_insn_decoder;
  import lid_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  inByte = '0;
  logic        inValid = 1'b0;
  logic        inLast = 1'b0;
  logic        inReady;
  logic [15:0] shortWord;
  logic        shortQuery;
  logic        shortOk;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [2:0]  outLen;
  logic        outFail;
  logic [4:0]  outOpcode;
  logic [23:0] outSlots;
  logic [2:0]  outCount;
  logic [5:0]  outImm;
  logic [5:0]  outBitPos;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // Stand-in short decoder: accepts every word whose major field is below 0x1C.
  assign shortOk = shortQuery && (shortWord[15:11] < 5'h1C);

  long_insn_decoder dut (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .shortWord(shortWord), .shortQuery(shortQuery), .shortOk(shortOk),
    .outValid(outValid), .outReady(outReady), .outLen(outLen), .outFail(outFail),
    .outOpcode(outOpcode), .outSlots(outSlots), .outCount(outCount), .outImm(outImm),
    .outBitPos(outBitPos)
  );

  function automatic logic [10:0] enc3(input int a, input int b, input int c);
    int k;
    k = a / 4 + 3 * (b / 4) + 9 * (c / 4);
    return {5'(k), 2'(a % 4), 2'(b % 4), 2'(c % 4)};
  endfunction

  function automatic logic [10:0] enc2(input int a, input int b);
    int k;
    k = a / 4 + 3 * (b / 4);
    if (k < 5) return {5'(k + 27), 2'b00, 2'(a % 4), 2'(b % 4)};
    return {5'(k + 22), 2'b10, 2'(a % 4), 2'(b % 4)};
  endfunction

  function automatic logic [15:0] extHi(input logic [8:0] x);
    return {x[8:4], 7'b0, x[3:0]};
  endfunction

  function automatic logic [23:0] pk(input int a, input int b, input int c,
                                     input int d, input int e, input int f);
    return {4'(f), 4'(e), 4'(d), 4'(c), 4'(b), 4'(a)};
  endfunction

  typedef struct packed {
    logic [31:0] word;
    logic [4:0]  opc;
    logic        fail;
    logic [2:0]  cnt;
    logic [23:0] slots;
    logic [5:0]  imm;
    logic [5:0]  bp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    // R4 three-register extended forms
    '{{extHi(9'h01c), 5'h1F, enc3(1, 5, 9)},   OPC_XOR,  1'b0, 3'd3, pk(1, 5, 9, 0, 0, 0),   6'd0, 6'd0, 4'd4},
    '{{extHi(9'h00c), 5'h1F, enc3(11, 0, 6)},  OPC_STW,  1'b0, 3'd3, pk(11, 0, 6, 0, 0, 0),  6'd0, 6'd0, 4'd4},
    '{{extHi(9'h19c), 5'h1F, enc3(2, 3, 4)},   OPC_REMU, 1'b0, 3'd3, pk(2, 3, 4, 0, 0, 0),   6'd0, 6'd0, 4'd4},
    '{{extHi(9'h07c), 5'h1F, enc3(10, 10, 10)},OPC_MUL,  1'b0, 3'd3, pk(10, 10, 10, 0, 0, 0),6'd0, 6'd0, 4'd4},
    // R5 immediate and bit-position forms
    '{{extHi(9'h12c), 5'h1F, enc3(7, 8, 0)},   OPC_ASHRI,1'b0, 3'd3, pk(7, 8, 0, 0, 0, 0),   6'd4, 6'd32, 4'd5},
    '{{extHi(9'h12e), 5'h1F, enc3(10, 1, 9)},  OPC_INP,  1'b0, 3'd3, pk(10, 1, 9, 0, 0, 0),  6'd4, 6'd16, 4'd5},
    '{{extHi(9'h14c), 5'h1F, enc3(4, 4, 11)},  OPC_LAWBI,1'b0, 3'd3, pk(4, 4, 11, 0, 0, 0),  6'd4, 6'd0, 4'd5},
    // R6 CRC
    '{{extHi(9'h15c), 5'h1F, enc3(3, 6, 9)},   OPC_CRC,  1'b0, 3'd4, pk(3, 3, 6, 9, 0, 0),   6'd0, 6'd0, 4'd6},
    // R7 unknown extended value
    '{{extHi(9'h16c), 5'h1F, enc3(3, 6, 9)},   OPC_NONE, 1'b1, 3'd0, 24'd0,                  6'd0, 6'd0, 4'd7},
    // R8 two-operand low halfword
    '{{16'h0000, 5'h1F, enc2(6, 10)},          OPC_WIDE2R,1'b0,3'd2, pk(6, 10, 0, 0, 0, 0),  6'd0, 6'd0, 4'd8},
    '{{16'h0000, 5'h1F, 5'd31, 6'b000110},     OPC_WIDE2R,1'b0,3'd2, pk(5, 6, 0, 0, 0, 0),   6'd0, 6'd0, 4'd8},
    // R4 combined 31 with bit 5: not two-operand, and not three-operand either
    '{{extHi(9'h01c), 5'h1F, 5'd31, 6'b100000},OPC_NONE, 1'b1, 3'd0, 24'd0,                  6'd0, 6'd0, 4'd4},
    // R9 five-register
    '{{5'h03, enc2(4, 5), 5'h1E, enc3(1, 2, 3)},  OPC_REG5, 1'b0, 3'd5, pk(1, 4, 2, 3, 5, 0), 6'd0, 6'd0, 4'd9},
    // R10 six-register fallback and its failures
    '{{5'h00, enc3(8, 9, 10), 5'h1E, enc3(0, 7, 11)}, OPC_LMUL6, 1'b0, 3'd6, pk(0, 8, 7, 11, 9, 10), 6'd0, 6'd0, 4'd10},
    '{{5'h01, enc3(8, 9, 10), 5'h1E, enc3(0, 7, 11)}, OPC_NONE, 1'b1, 3'd0, 24'd0, 6'd0, 6'd0, 4'd10},
    '{{5'h00, enc2(1, 1), 5'h1E, 5'd27, 6'd0},        OPC_NONE, 1'b1, 3'd0, 24'd0, 6'd0, 6'd0, 4'd10},
    // R11 four-register source/destination forms
    '{{16'h0007, 5'h1D, enc3(2, 5, 8)},        OPC_SD4,  1'b0, 3'd5, pk(2, 7, 7, 5, 8, 0),   6'd0, 6'd0, 4'd11},
    '{{16'h000C, 5'h1D, enc3(2, 5, 8)},        OPC_NONE, 1'b1, 3'd0, 24'd0,                  6'd0, 6'd0, 4'd11},
    '{{16'h000B, 5'h1C, enc3(1, 2, 3)},        OPC_SDSD4,1'b0, 3'd6, pk(1, 11, 1, 11, 2, 3), 6'd0, 6'd0, 4'd11}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic last);
    @(negedge clk);
    inByte = b; inValid = 1'b1; inLast = last;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1;
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic sendWord(input logic [31:0] w);
    for (int i = 0; i < 4; i++) sendByte(w[i*8 +: 8], 1'b0);
  endtask

  task automatic expectRes(input string req, input logic [2:0] len, input logic fail,
                           input logic [4:0] opc, input logic [2:0] cnt,
                           input logic [23:0] slots, input logic [5:0] imm,
                           input logic [5:0] bp);
    @(negedge clk);
    while (!outValid) @(negedge clk);
    check(req, "length", 32'(outLen), 32'(len));
    check(req, "fail", 32'(outFail), 32'(fail));
    check(req, "opcode", 32'(outOpcode), 32'(opc));
    check(req, "count", 32'(outCount), 32'(cnt));
    check(req, "slots", 32'(outSlots), 32'(slots));
    check(req, "imm flags", 32'(outImm), 32'(imm));
    check(req, "bit position", 32'(outBitPos), 32'(bp));
    check("R12", "ready while held", 32'(inReady), 32'd0);
    @(negedge clk);
    check("R12", "still valid", 32'(outValid), 32'd1);
    check("R12", "slots held", 32'(outSlots), 32'(slots));
    outReady = 1'b1;
    @(posedge clk);
    #1;
    outReady = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL R12 watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // reset state (R12)
    check("R12", "reset outValid", 32'(outValid), 32'd0);
    check("R12", "reset inReady", 32'(inReady), 32'd1);
    check("R3", "reset length", 32'(outLen), 32'd0);

    // R1 / R2: short word accepted, little-endian halfword
    sendByte(8'h34, 1'b0);
    sendByte(8'h12, 1'b0);
    @(negedge clk);
    check("R1", "query active", 32'(shortQuery), 32'd1);
    check("R1", "short word order", 32'(shortWord), 32'h1234);
    expectRes("R2", 3'd2, 1'b0, OPC_SHORT, 3'd0, 24'd0, 6'd0, 6'd0);

    // Vector table over the long-format rules (R1 byte order on every word)
    for (int i = 0; i < NV; i++) begin
      sendWord(VECS[i].word);
      expectRes($sformatf("R%0d", VECS[i].req), 3'd4, VECS[i].fail, VECS[i].opc,
                VECS[i].cnt, VECS[i].slots, VECS[i].imm, VECS[i].bp);
    end

    // R3: truncated streams
    sendByte(8'h00, 1'b1);
    expectRes("R3", 3'd0, 1'b1, OPC_NONE, 3'd0, 24'd0, 6'd0, 6'd0);
    sendByte(8'h00, 1'b0);
    sendByte(8'hF8, 1'b1);
    expectRes("R3", 3'd0, 1'b1, OPC_NONE, 3'd0, 24'd0, 6'd0, 6'd0);
    sendByte(8'h00, 1'b0);
    sendByte(8'hF8, 1'b0);
    sendByte(8'h01, 1'b1);
    expectRes("R3", 3'd0, 1'b1, OPC_NONE, 3'd0, 24'd0, 6'd0, 6'd0);

    // R2: last byte on a short-accepted word still yields length 2
    sendByte(8'h55, 1'b0);
    sendByte(8'h20, 1'b1);
    expectRes("R2", 3'd2, 1'b0, OPC_SHORT, 3'd0, 24'd0, 6'd0, 6'd0);

    // R1: long word after a short one, byte order of the upper halfword
    sendWord({extHi(9'h02c), 5'h1F, enc3(9, 2, 1)});
    expectRes("R1", 3'd4, 1'b0, OPC_ASHR, 3'd3, pk(9, 2, 1, 0, 0, 0), 6'd0, 6'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule